// File: doc/BRIEF.md
# UART FIFO Line Status and Interrupt Identification

This block forms the line status byte and the interrupt identification code of a 16550-style UART that has receive and transmit FIFOs. It does not hold any characters itself. The FIFOs, the serial shifters and the register bus sit around it and send in their state: FIFO occupancy, shift-register activity, per-character error pulses, the trigger-level and character-timeout conditions, and the current FIFO-enable and interrupt-enable settings. From these inputs the block produces a registered status byte, a registered 4-bit identification code and an interrupt request line.

The receive side and the transmit side each choose their mode on their own. When the FIFOs are enabled and a side's interrupt enable is cleared, that side runs polled. A polled side never reports a trigger-level or timeout interrupt, but its status bits still follow the FIFO contents. Error bits are sticky and clear when software reads the status byte. The identification code always names the highest-priority source that is both pending and enabled.

Top module: `uart_fifo_stat`

## Requirements
- R1: While `rst` is high, on each clock edge `lsr` becomes 8'h60, `iir` becomes 4'b0001 and `irq` becomes 0.
- R2: All outputs are registered and reflect the inputs one clock edge later. `lsr[0]` is 1 when `rx_level` is non-zero.
- R3: `rx_char_err[3:0]` holds pulses for overrun, parity, framing and break, in that bit order. Each pulse sets `lsr[1]`, `lsr[2]`, `lsr[3]` and `lsr[4]` respectively, and the bit stays set. A cycle with `lsr_rd` high clears all four bits, but an error pulse arriving in the same cycle still sets its bit.
- R4: `lsr[5]` is 1 when `tx_level` is zero. `lsr[6]` is 1 only when `tx_level` is zero and `tx_shift_busy` is 0.
- R5: `lsr[7]` equals `rx_err_in_fifo` while `fifo_en` is 1, and is 0 while `fifo_en` is 0.
- R6: Sources rank from highest to lowest: line status (`ier[2]` with any sticky error bit, code 4'b0110), then receive data, then transmitter empty (`ier[1]` with `tx_level` zero, code 4'b0010), then modem (`ier[3]` with `modem_change`, code 4'b0000). When no source is pending and enabled, the code is 4'b0001.
- R7: With `fifo_en`=1 and `ier[0]`=1, `rx_trig_hit` gives code 4'b0100. If `rx_trig_hit` is 0, `rx_timeout` gives code 4'b1100. With `fifo_en`=0 and `ier[0]`=1, a non-zero `rx_level` gives 4'b0100 and `rx_timeout` is ignored.
- R8: With `fifo_en`=1 and `ier[0]`=0, the receive side is polled. `rx_trig_hit` and `rx_timeout` never produce code 4'b0100 or 4'b1100, while `lsr[0]` still follows `rx_level`.
- R9: The transmit side is enabled on its own. With `ier[1]`=1 and the receive side polled, an empty transmit FIFO still gives code 4'b0010.
- R10: `irq` is 1 exactly when `iir[0]` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_en | input | 1 | FIFO enable (FIFO control bit 0) |
| ier | input | 4 | Interrupt enables: rx data, tx empty, line status, modem |
| rx_level | input | CNT_W | Characters held in the receive FIFO |
| rx_char_err | input | 4 | Error pulses: overrun, parity, framing, break |
| rx_err_in_fifo | input | 1 | Some character in the receive FIFO carries an error |
| rx_trig_hit | input | 1 | Receive FIFO at or above its trigger level |
| rx_timeout | input | 1 | Character timeout condition |
| tx_level | input | CNT_W | Characters held in the transmit FIFO |
| tx_shift_busy | input | 1 | Transmit shift register holds data |
| modem_change | input | 1 | Modem status change pending |
| lsr_rd | input | 1 | Status byte read strobe |
| lsr | output | 8 | Line status byte |
| iir | output | 4 | Interrupt identification code |
| irq | output | 1 | Interrupt request |

## Verification
The bench drives trigger and timeout together with the receive side polled. A design that does not gate the receive side would report 4'b0100 or 4'b1100 there, and the bench also checks that the transmit-empty code still gets through in that state. It applies an error pulse in the same cycle as a status read: a design where the clear wins would lose that error. It also raises a line-status error alongside a trigger hit, and a modem change alongside an empty transmitter, so that a wrong priority order shows up in the code. Further checks cover the timeout being ignored when the FIFOs are off, `lsr[7]` being forced low when the FIFOs are off, and the case where the FIFO is empty but the shifter is still busy, which must separate `lsr[5]` from `lsr[6]`.

// File: rtl/uart_stat_pkg.sv
package uart_stat_pkg;
  typedef enum logic [3:0] {
    IIR_NONE = 4'b0001,
    IIR_LINE = 4'b0110,
    IIR_RXDA = 4'b0100,
    IIR_RXTO = 4'b1100,
    IIR_TXEM = 4'b0010,
    IIR_MODM = 4'b0000
  } iir_code_e;

  localparam int ERR_BITS = 4;
endpackage

// File: rtl/uart_err_sticky.sv
module uart_err_sticky #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic [N-1:0] set,
  output logic [N-1:0] nxt,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    // a new error in the read cycle survives the clear
    assign nxt[i] = set[i] | (q[i] & ~clr);
    always_ff @(posedge clk) begin
      if (rst) q[i] <= 1'b0;
      else     q[i] <= nxt[i];
    end
  end

  a_r3_set_sticks: assert property (@(posedge clk) disable iff (rst)
    (set != '0) |=> ((q & $past(set)) == $past(set)));
endmodule

// File: rtl/uart_lsr_gen.sv
module uart_lsr_gen #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fifo_en,
  input  logic [CNT_W-1:0] rx_level,
  input  logic [3:0]       err_nxt,
  input  logic             rx_err_in_fifo,
  input  logic [CNT_W-1:0] tx_level,
  input  logic             tx_shift_busy,
  input  logic             lsr_rd,
  input  logic [3:0]       rx_char_err,
  output logic [7:0]       lsr
);
  logic tx_empty;
  assign tx_empty = (tx_level == '0);

  always_ff @(posedge clk) begin
    if (rst) lsr <= 8'h60;
    else     lsr <= {fifo_en & rx_err_in_fifo,
                     tx_empty & ~tx_shift_busy,
                     tx_empty,
                     err_nxt,
                     rx_level != '0};
  end

  a_r2_data_ready: assert property (@(posedge clk) disable iff (rst)
    (rx_level != '0) |=> lsr[0]);
  a_r4_temt_needs_thre: assert property (@(posedge clk) disable iff (rst)
    lsr[6] |-> lsr[5]);
  a_r3_read_clears: assert property (@(posedge clk) disable iff (rst)
    (lsr_rd && rx_char_err == '0) |=> (lsr[4:1] == 4'b0));
  a_r5_no_fifo_no_err: assert property (@(posedge clk) disable iff (rst)
    !fifo_en |=> !lsr[7]);
endmodule

// File: rtl/uart_irq_arb.sv
module uart_irq_arb
  import uart_stat_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fifo_en,
  input  logic [3:0]       ier,
  input  logic [3:0]       err_nxt,
  input  logic [CNT_W-1:0] rx_level,
  input  logic             rx_trig_hit,
  input  logic             rx_timeout,
  input  logic [CNT_W-1:0] tx_level,
  input  logic             modem_change,
  output logic [3:0]       iir,
  output logic             irq
);
  iir_code_e code;
  logic line_p, rxda_p, rxto_p, txem_p, modm_p;

  always_comb begin
    line_p = ier[2] & (err_nxt != '0);
    if (fifo_en) begin
      rxda_p = ier[0] & rx_trig_hit;
      rxto_p = ier[0] & rx_timeout;
    end else begin
      rxda_p = ier[0] & (rx_level != '0);
      rxto_p = 1'b0;
    end
    txem_p = ier[1] & (tx_level == '0);
    modm_p = ier[3] & modem_change;

    if (line_p)      code = IIR_LINE;
    else if (rxda_p) code = IIR_RXDA;
    else if (rxto_p) code = IIR_RXTO;
    else if (txem_p) code = IIR_TXEM;
    else if (modm_p) code = IIR_MODM;
    else             code = IIR_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      iir <= IIR_NONE;
      irq <= 1'b0;
    end else begin
      iir <= code;
      irq <= (code != IIR_NONE);
    end
  end

  a_r10_irq_vs_code: assert property (@(posedge clk) disable iff (rst)
    irq == !iir[0]);
  a_r8_polled_rx_quiet: assert property (@(posedge clk) disable iff (rst)
    (fifo_en && !ier[0]) |=> (iir != IIR_RXDA && iir != IIR_RXTO));
  a_r6_line_first: assert property (@(posedge clk) disable iff (rst)
    (ier[2] && err_nxt != '0) |=> (iir == IIR_LINE));
  a_r9_tx_independent: assert property (@(posedge clk) disable iff (rst)
    (ier[1] && !ier[2] && !ier[0] && tx_level == '0) |=> (iir == IIR_TXEM));
endmodule

// File: rtl/uart_fifo_stat.sv
module uart_fifo_stat #(
  parameter int FIFO_DEPTH = 16,
  parameter int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fifo_en,
  input  logic [3:0]       ier,
  input  logic [CNT_W-1:0] rx_level,
  input  logic [3:0]       rx_char_err,
  input  logic             rx_err_in_fifo,
  input  logic             rx_trig_hit,
  input  logic             rx_timeout,
  input  logic [CNT_W-1:0] tx_level,
  input  logic             tx_shift_busy,
  input  logic             modem_change,
  input  logic             lsr_rd,
  output logic [7:0]       lsr,
  output logic [3:0]       iir,
  output logic             irq
);
  import uart_stat_pkg::*;

  logic [ERR_BITS-1:0] err_nxt, err_q;

  uart_err_sticky #(.N(ERR_BITS)) u_err (
    .clk(clk), .rst(rst), .clr(lsr_rd), .set(rx_char_err),
    .nxt(err_nxt), .q(err_q)
  );

  uart_lsr_gen #(.CNT_W(CNT_W)) u_lsr (
    .clk(clk), .rst(rst), .fifo_en(fifo_en), .rx_level(rx_level),
    .err_nxt(err_nxt), .rx_err_in_fifo(rx_err_in_fifo),
    .tx_level(tx_level), .tx_shift_busy(tx_shift_busy),
    .lsr_rd(lsr_rd), .rx_char_err(rx_char_err), .lsr(lsr)
  );

  uart_irq_arb #(.CNT_W(CNT_W)) u_arb (
    .clk(clk), .rst(rst), .fifo_en(fifo_en), .ier(ier), .err_nxt(err_nxt),
    .rx_level(rx_level), .rx_trig_hit(rx_trig_hit), .rx_timeout(rx_timeout),
    .tx_level(tx_level), .modem_change(modem_change), .iir(iir), .irq(irq)
  );

  a_r1_err_mirror: assert property (@(posedge clk) disable iff (rst)
    lsr[4:1] == err_q);
endmodule

// File: tb/uart_fifo_stat_tb.sv
module uart_fifo_stat_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 0, rst = 1;
  logic fifo_en = 0, rx_err_in_fifo = 0, rx_trig_hit = 0, rx_timeout = 0;
  logic tx_shift_busy = 0, modem_change = 0, lsr_rd = 0;
  logic [3:0] ier = 0, rx_char_err = 0;
  logic [CW-1:0] rx_level = 0, tx_level = 0;
  logic [7:0] lsr;
  logic [3:0] iir;
  logic irq;

  typedef struct { logic [7:0] lsr; logic [3:0] iir; string tag; } exp_t;
  exp_t sb[$];
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_fifo_stat #(.FIFO_DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst(rst), .fifo_en(fifo_en), .ier(ier), .rx_level(rx_level),
    .rx_char_err(rx_char_err), .rx_err_in_fifo(rx_err_in_fifo),
    .rx_trig_hit(rx_trig_hit), .rx_timeout(rx_timeout), .tx_level(tx_level),
    .tx_shift_busy(tx_shift_busy), .modem_change(modem_change),
    .lsr_rd(lsr_rd), .lsr(lsr), .iir(iir), .irq(irq)
  );

  // driver: inputs are already set at the falling edge; queue expectation, wait
  task automatic step(input logic [7:0] el, input logic [3:0] ei, input string tag);
    sb.push_back('{el, ei, tag});
    @(negedge clk);
  endtask

  // monitor: compare just after each rising edge
  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (lsr !== e.lsr || iir !== e.iir || irq !== (e.iir != 4'b0001)) begin
        errors++;
        $display("FAIL %s: lsr=%h iir=%b irq=%b expected lsr=%h iir=%b irq=%b",
                 e.tag, lsr, iir, irq, e.lsr, e.iir, e.iir != 4'b0001);
      end
    end
  end

  initial begin
    @(negedge clk);
    rx_level = 5; tx_level = 3; ier = 4'hF; rx_char_err = 4'b0001;
    step(8'h60, 4'b0001, "R1 reset");
    rst = 0; rx_char_err = 0; rx_level = 0; tx_level = 0; ier = 0; fifo_en = 1;
    step(8'h60, 4'b0001, "R1 idle after reset");
    rx_level = 3; rx_trig_hit = 1; rx_timeout = 1;
    step(8'h61, 4'b0001, "R2 R8 polled rx, data ready live");
    ier = 4'b0010;
    step(8'h61, 4'b0010, "R9 tx empty while rx polled");
    ier = 4'b0011;
    step(8'h61, 4'b0100, "R7 trigger code");
    rx_trig_hit = 0;
    step(8'h61, 4'b1100, "R7 timeout code");
    fifo_en = 0; ier = 4'b0001; rx_level = 0;
    step(8'h60, 4'b0001, "R7 timeout ignored without fifo");
    rx_level = 2;
    step(8'h61, 4'b0100, "R7 data ready code without fifo");
    rx_timeout = 0; fifo_en = 1; rx_err_in_fifo = 1; ier = 0;
    step(8'hE1, 4'b0001, "R5 error in fifo");
    fifo_en = 0;
    step(8'h61, 4'b0001, "R5 bit7 forced low without fifo");
    fifo_en = 1; rx_err_in_fifo = 0; ier = 4'b0111; rx_trig_hit = 1; rx_char_err = 4'b0010;
    step(8'h65, 4'b0110, "R3 R6 parity error beats trigger");
    rx_trig_hit = 0; rx_char_err = 4'b0100;
    step(8'h6D, 4'b0110, "R3 errors accumulate");
    rx_char_err = 0;
    step(8'h6D, 4'b0110, "R3 errors held");
    lsr_rd = 1;
    step(8'h61, 4'b0010, "R3 read clears errors");
    rx_char_err = 4'b1000;
    step(8'h71, 4'b0110, "R3 error set wins over read");
    rx_char_err = 0; tx_level = 5;
    step(8'h01, 4'b0001, "R4 tx fifo holds data");
    lsr_rd = 0; tx_level = 0; tx_shift_busy = 1;
    step(8'h21, 4'b0010, "R4 fifo empty shifter busy");
    tx_shift_busy = 0; rx_level = 0; ier = 4'b1000; modem_change = 1;
    step(8'h60, 4'b0000, "R6 R10 modem code raises irq");
    ier = 4'b1010;
    step(8'h60, 4'b0010, "R6 tx empty over modem");
    step(8'h60, 4'b0010, "R6 steady");
    @(negedge clk);
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 2000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule